// File: doc/BRIEF.md
# Accumulator Datapath with Input and Store Scalers

This block is the arithmetic core of a fixed-point signal processor. It holds a 32-bit accumulator and a carry flag. A 16-bit data-bus operand passes through an input scaler. The scaler widens the operand to 32 bits and shifts it left by a count of 0 to 16. An ALU then combines the accumulator with either that scaled operand or a 32-bit product input. Every ALU result is written back to the accumulator on the next clock edge.

For storage, a second shifter scales the accumulator on its way out. One 16-bit half is driven onto the store bus, and the accumulator itself does not change. The block also performs single normalize steps, each counted on an output counter, and a single-bit test of the data operand. Instruction decode, memories, the multiplier and branching all belong to neighbouring logic, which drives this block's opcode, select and count inputs each cycle.

Top module: `acc_datapath`

## Requirements
- R1: The scaled operand is the widened `din` shifted left by `shift_cnt`, with zeros entering at bit 0. A `shift_cnt` above 16 acts as 16.
- R2: With `sxm` = 1 the widened operand copies `din[15]` into bits 31..16. With `sxm` = 0 those bits are zero.
- R3: The second ALU operand is the scaled operand when `src_sel` = 0 and `prod_in` when `src_sel` = 1.
- R4: `opcode` 000 loads the operand, 001 adds it, 010 subtracts it from the accumulator, 011 ANDs, 100 ORs and 101 XORs it over all 32 bits. The result is in `acc` after the next rising clock edge.
- R5: `opcode` 111 leaves the accumulator, carry and normalize count unchanged.
- R6: On add, `carry` takes the carry out of bit 31. On subtract, `carry` is 1 when a borrow occurs, that is, when the accumulator is below the operand as unsigned numbers. Every other opcode leaves `carry` unchanged.
- R7: `st_data` is bits 31..16 (`st_half` = 1) or bits 15..0 (`st_half` = 0) of the accumulator shifted left by `st_shift` (0 to 7), with zeros entering at bit 0. It follows the current accumulator in the same cycle and never alters it.
- R8: `norm_done` is high when accumulator bits 31 and 30 differ. For `opcode` 110, if `norm_done` is low the accumulator shifts left by one and `norm_cnt` increments; if `norm_done` is high nothing changes.
- R9: A load (`opcode` 000) clears `norm_cnt`.
- R10: `bit_out` equals `din[bit_idx]`, where `bit_idx` 15 selects the MSB.
- R11: While `rst_n` is low, the accumulator, carry and normalize count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 3 | Operation select |
| src_sel | input | 1 | 0 = scaled data operand, 1 = product input |
| sxm | input | 1 | Sign-extension mode for the input scaler |
| shift_cnt | input | 5 | Input scaler left-shift count |
| din | input | 16 | Data-bus operand |
| prod_in | input | 32 | Product operand |
| st_half | input | 1 | Store half select, 1 = high |
| st_shift | input | 3 | Store left-shift count |
| bit_idx | input | 4 | Bit-test index |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry/borrow flag |
| st_data | output | 16 | Scaled accumulator half for storage |
| norm_done | output | 1 | Accumulator is normalized |
| norm_cnt | output | 6 | Normalize step count |
| bit_out | output | 1 | Selected operand bit |

## Verification
A store readout and an accumulator update can happen in the same cycle. `st_data` must show the old accumulator up to the edge and the new one after it. The bench drives an add and a store selection together, then samples `st_data` once before the rising edge and once after it. The first sample must match the pre-add value and the second the post-add value. Normalize steps are judged the same way: the run stops exactly when bits 31 and 30 first differ, and the step count matches the number of shifts made.

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DW  = 16,
  parameter int STW = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  opcode,
  input  logic                        src_sel,
  input  logic                        sxm,
  input  logic [$clog2(DW+1)-1:0]     shift_cnt,
  input  logic [DW-1:0]               din,
  input  logic [2*DW-1:0]             prod_in,
  input  logic                        st_half,
  input  logic [STW-1:0]              st_shift,
  input  logic [$clog2(DW)-1:0]       bit_idx,
  output logic [2*DW-1:0]             acc,
  output logic                        carry,
  output logic [DW-1:0]               st_data,
  output logic                        norm_done,
  output logic [$clog2(2*DW):0]       norm_cnt,
  output logic                        bit_out
);
  localparam int AW  = 2 * DW;
  localparam int SCW = $clog2(DW + 1);

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_XOR = 3'd5;
  localparam logic [2:0] OP_NRM = 3'd6;

  logic [SCW-1:0] sh_eff;
  logic [AW-1:0]  wide, scaled, opnd, acc_sh;
  logic [AW:0]    sum, dif;

  assign sh_eff  = (shift_cnt > SCW'(DW)) ? SCW'(DW) : shift_cnt;
  assign wide    = sxm ? {{DW{din[DW-1]}}, din} : {{DW{1'b0}}, din};
  assign scaled  = wide << sh_eff;
  assign opnd    = src_sel ? prod_in : scaled;
  assign sum     = {1'b0, acc} + {1'b0, opnd};
  assign dif     = {1'b0, acc} - {1'b0, opnd};
  assign acc_sh  = acc << st_shift;
  assign st_data = st_half ? acc_sh[AW-1:DW] : acc_sh[DW-1:0];
  assign norm_done = acc[AW-1] ^ acc[AW-2];
  assign bit_out = din[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      carry    <= 1'b0;
      norm_cnt <= '0;
    end else begin
      unique case (opcode)
        OP_LD:  begin acc <= opnd; norm_cnt <= '0; end
        OP_ADD: begin acc <= sum[AW-1:0]; carry <= sum[AW]; end
        OP_SUB: begin acc <= dif[AW-1:0]; carry <= dif[AW]; end
        OP_AND: acc <= acc & opnd;
        OP_OR:  acc <= acc | opnd;
        OP_XOR: acc <= acc ^ opnd;
        OP_NRM: if (!norm_done) begin
                  acc      <= acc << 1;
                  norm_cnt <= norm_cnt + 1'b1;
                end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (rst_n) begin
      a_r1_low_zero: assert ((scaled & ~({AW{1'b1}} << sh_eff)) == '0);
    end
  end

  a_r5_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == 3'd7 |=> $stable(acc) && $stable(carry) && $stable(norm_cnt));

  a_r6_carry_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode != OP_ADD && opcode != OP_SUB) |=> $stable(carry));

  a_r8_norm_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_NRM && norm_done) |=> $stable(acc) && $stable(norm_cnt));

  a_r9_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == OP_LD |=> norm_cnt == '0);

  a_r3_prod_load: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_LD && src_sel) |=> acc == $past(prod_in));

endmodule

// File: tb/acc_datapath_tb_top.sv
module acc_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  opcode;
  logic        src_sel, sxm, st_half, carry, norm_done, bit_out;
  logic [4:0]  shift_cnt;
  logic [15:0] din, st_data;
  logic [31:0] prod_in, acc;
  logic [2:0]  st_shift;
  logic [3:0]  bit_idx;
  logic [5:0]  norm_cnt;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  acc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .src_sel(src_sel), .sxm(sxm),
    .shift_cnt(shift_cnt), .din(din), .prod_in(prod_in), .st_half(st_half),
    .st_shift(st_shift), .bit_idx(bit_idx), .acc(acc), .carry(carry),
    .st_data(st_data), .norm_done(norm_done), .norm_cnt(norm_cnt), .bit_out(bit_out)
  );

  // op, src, sxm, shift, din, prod, expected acc, expected carry
  localparam int NV = 13;
  localparam logic [90:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 5'd0,  16'h8000, 32'h0,        32'hFFFF8000, 1'b0},
    {3'd0, 1'b0, 1'b0, 5'd4,  16'h8000, 32'h0,        32'h00080000, 1'b0},
    {3'd0, 1'b0, 1'b1, 5'd16, 16'h8001, 32'h0,        32'h80010000, 1'b0},
    {3'd1, 1'b1, 1'b0, 5'd0,  16'h0,    32'h80000000, 32'h00010000, 1'b1},
    {3'd2, 1'b0, 1'b0, 5'd0,  16'h0001, 32'h0,        32'h0000FFFF, 1'b0},
    {3'd2, 1'b0, 1'b0, 5'd0,  16'hFFFF, 32'h0,        32'h00000000, 1'b0},
    {3'd2, 1'b0, 1'b0, 5'd0,  16'h0001, 32'h0,        32'hFFFFFFFF, 1'b1},
    {3'd3, 1'b1, 1'b0, 5'd0,  16'h0,    32'h0F0F0F0F, 32'h0F0F0F0F, 1'b1},
    {3'd4, 1'b0, 1'b1, 5'd8,  16'h00F0, 32'h0,        32'h0F0FFF0F, 1'b1},
    {3'd5, 1'b1, 1'b0, 5'd0,  16'h0,    32'hFFFFFFFF, 32'hF0F000F0, 1'b1},
    {3'd7, 1'b1, 1'b0, 5'd0,  16'h0,    32'h12345678, 32'hF0F000F0, 1'b1},
    {3'd1, 1'b0, 1'b1, 5'd0,  16'h0010, 32'h0,        32'hF0F00100, 1'b0},
    {3'd0, 1'b0, 1'b0, 5'd20, 16'h0001, 32'h0,        32'h00010000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic src, input logic [31:0] p);
    opcode = op; src_sel = src; prod_in = p;
    @(negedge clk);
    opcode = 3'd7;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 3'd7; src_sel = 1'b0; sxm = 1'b0; shift_cnt = '0;
    din = '0; prod_in = '0; st_half = 1'b0; st_shift = '0; bit_idx = '0;
    repeat (3) @(negedge clk);
    chk("R11 acc", acc, 32'h0);
    chk("R11 carry", {31'h0, carry}, 32'h0);
    chk("R11 cnt", {26'h0, norm_cnt}, 32'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      sxm = VEC[i][86]; shift_cnt = VEC[i][85:81]; din = VEC[i][80:65];
      step(VEC[i][90:88], VEC[i][87], VEC[i][64:33]);
      chk($sformatf("R4 vec%0d acc", i), acc, VEC[i][32:1]);
      chk($sformatf("R6 vec%0d carry", i), {31'h0, carry}, {31'h0, VEC[i][0]});
    end

    // R7 store scaling
    step(3'd0, 1'b1, 32'h12345678);
    st_half = 1'b1; st_shift = 3'd0; #1 chk("R7 hi0", {16'h0, st_data}, 32'h1234);
    st_shift = 3'd4; #1 chk("R7 hi4", {16'h0, st_data}, 32'h2345);
    st_half = 1'b0; #1 chk("R7 lo4", {16'h0, st_data}, 32'h6780);
    st_shift = 3'd0; #1 chk("R7 lo0", {16'h0, st_data}, 32'h5678);
    @(negedge clk);
    chk("R7 acc unchanged", acc, 32'h12345678);

    // R7 store and add in the same cycle
    opcode = 3'd1; src_sel = 1'b1; prod_in = 32'h1;
    @(posedge clk); #1;
    @(negedge clk);
    opcode = 3'd7;
    chk("R7 store after add", {16'h0, st_data}, 32'h5679);
    opcode = 3'd1; prod_in = 32'h1;
    #1 chk("R7 store before add", {16'h0, st_data}, 32'h5679);
    @(negedge clk); opcode = 3'd7;
    chk("R7 store next", {16'h0, st_data}, 32'h567A);

    // R8 normalize
    step(3'd0, 1'b1, 32'h00000003);
    chk("R9 cnt cleared", {26'h0, norm_cnt}, 32'h0);
    opcode = 3'd6;
    repeat (29) @(negedge clk);
    opcode = 3'd7;
    chk("R8 norm acc", acc, 32'h60000000);
    chk("R8 norm cnt", {26'h0, norm_cnt}, 32'd29);
    chk("R8 norm done", {31'h0, norm_done}, 32'h1);
    step(3'd6, 1'b1, 32'h0);
    chk("R8 extra step acc", acc, 32'h60000000);
    chk("R8 extra step cnt", {26'h0, norm_cnt}, 32'd29);
    step(3'd0, 1'b1, 32'hC0000000);
    chk("R8 neg not done", {31'h0, norm_done}, 32'h0);
    step(3'd6, 1'b1, 32'h0);
    chk("R8 neg acc", acc, 32'h80000000);
    chk("R8 neg cnt", {26'h0, norm_cnt}, 32'd1);
    step(3'd0, 1'b1, 32'h5);
    chk("R9 load clears", {26'h0, norm_cnt}, 32'h0);

    // R10 bit test
    din = 16'h8001;
    bit_idx = 4'd15; #1 chk("R10 b15", {31'h0, bit_out}, 32'h1);
    bit_idx = 4'd0;  #1 chk("R10 b0",  {31'h0, bit_out}, 32'h1);
    bit_idx = 4'd1;  #1 chk("R10 b1",  {31'h0, bit_out}, 32'h0);

    // R5 nop hold
    step(3'd7, 1'b1, 32'hFFFFFFFF);
    chk("R5 nop acc", acc, 32'h5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule